// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block steps a programmable device from power-up to user mode. It waits for supply settling and then for the external clearing of configuration memory. It then waits on a shared active-low open-drain init line, grants data loading, and finally hands the I/O to the user design. While configuration is in progress it holds a high-level status flag high and a low-level status flag low. When the I/O go active it releases both flags and stops pulling on init.

The init line is shared. The block pulls it low while supplies settle, while memory is cleared, and after a loading error. An outside agent can also hold it low to keep the block waiting. The pad itself is outside the block: the block only gives a pull-low enable and receives the sensed level. The sensed level is synchronised through two flops before any decision uses it. In master mode, a further programmable wait follows the release of init before loading is granted. Memory clearing, bitstream parsing and CRC checking are done elsewhere and are reported to the block as one-cycle strobes.

Top module: `cfg_startup_seq`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge), `init_pull_low`=1, `cfg_busy_hi`=1, `cfg_busy_lo`=0, `load_grant`=0 and `io_active`=0.
- R2: The power-settle phase lasts exactly `SETTLE_CYCLES` clock edges after reset is released, and `clear_done` is ignored during it.
- R3: After power settling, `init_pull_low` stays 1 until a `clear_done` strobe is seen. After that strobe it becomes 0.
- R4: While the synchronised init level is low, the block stays waiting: `load_grant` stays 0 and `init_pull_low` stays 0.
- R5: In slave mode (`master_mode`=0), `load_grant` rises on the third rising clock edge after `init_in` goes high during the wait phase, and not before.
- R6: In master mode (`master_mode`=1), `load_grant` rises `MASTER_WAIT` edges later than in slave mode, on edge 3+`MASTER_WAIT` after `init_in` goes high.
- R7: A `crc_err` strobe while `load_grant`=1 moves the block into a sticky error state. In that state `init_pull_low`=1, `load_grant`=0 and `io_active`=0 until reset. `crc_err` takes precedence over a `load_done` in the same cycle.
- R8: A `load_done` strobe while `load_grant`=1 sets `io_active`=1 on that edge. It also sets `cfg_busy_hi`=0, `cfg_busy_lo`=1, `init_pull_low`=0 and `load_grant`=0.
- R9: Once `io_active`=1 it stays 1 until reset, whatever `crc_err`, `load_done` or `init_in` do.
- R10: `crc_err` and `load_done` strobes have no effect while loading is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 adds the post-release wait before loading |
| init_in | input | 1 | Sensed level of the shared init line (asynchronous) |
| clear_done | input | 1 | Strobe: configuration memory clearing finished |
| load_done | input | 1 | Strobe: configuration data fully loaded |
| crc_err | input | 1 | Strobe: configuration data error detected |
| init_pull_low | output | 1 | 1 enables the open-drain pull-down on init |
| cfg_busy_hi | output | 1 | High while configuring, 0 once released |
| cfg_busy_lo | output | 1 | Low while configuring, 1 once released |
| load_grant | output | 1 | 1 while configuration data may be loaded |
| io_active | output | 1 | 1 once user I/O are active |

## Verification
A wrong state shows up on `init_pull_low` and `load_grant` in the same cycle. Driving init in the wait phase, or failing to drive it after an error, appears on the pull-down enable on the edge where the state is entered. An off-by-one in either counter moves the `load_grant` rise by one edge, or changes whether a `clear_done` strobe on the last settle edge is taken. A latency of its own in the synchroniser moves the slave-mode grant edge. Leaving the error or done state appears on the next edge as a change in `init_pull_low` or `io_active`.

// File: rtl/cfg_startup_seq.sv
`timescale 1ns/1ps
module cfg_startup_seq #(
  parameter int SETTLE_CYCLES = 64,
  parameter int MASTER_WAIT   = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic init_in,
  input  logic clear_done,
  input  logic load_done,
  input  logic crc_err,
  output logic init_pull_low,
  output logic cfg_busy_hi,
  output logic cfg_busy_lo,
  output logic load_grant,
  output logic io_active
);
  localparam int MAXC = (SETTLE_CYCLES > MASTER_WAIT) ? SETTLE_CYCLES : MASTER_WAIT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] WAIT_LAST   = CW'(MASTER_WAIT - 1);

  typedef enum logic [2:0] {
    ST_POWER = 3'd0, ST_CLEAR = 3'd1, ST_WAIT = 3'd2, ST_MDLY = 3'd3,
    ST_LOAD  = 3'd4, ST_ERR   = 3'd5, ST_DONE = 3'd6
  } st_t;

  st_t           state, state_nx;
  logic [CW-1:0] cnt;
  logic          init_s1, init_s2;

  always_ff @(posedge clk) begin
    if (rst) {init_s2, init_s1} <= 2'b00;
    else     {init_s2, init_s1} <= {init_s1, init_in};
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_POWER: if (cnt == SETTLE_LAST) state_nx = ST_CLEAR;
      ST_CLEAR: if (clear_done) state_nx = ST_WAIT;
      ST_WAIT:  if (init_s2) state_nx = master_mode ? ST_MDLY : ST_LOAD;
      ST_MDLY:  if (cnt == WAIT_LAST) state_nx = ST_LOAD;
      ST_LOAD:  if (crc_err) state_nx = ST_ERR;
                else if (load_done) state_nx = ST_DONE;
      default:  state_nx = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_POWER;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= (state_nx != state) ? '0 : cnt + CW'(1);
    end
  end

  assign init_pull_low = (state == ST_POWER) || (state == ST_CLEAR) || (state == ST_ERR);
  assign io_active     = (state == ST_DONE);
  assign load_grant    = (state == ST_LOAD);
  assign cfg_busy_hi   = !io_active;
  assign cfg_busy_lo   = io_active;
endmodule

module cfg_startup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state,
  input logic       init_sync,
  input logic       init_pull_low,
  input logic       load_grant,
  input logic       io_active,
  input logic       crc_err,
  input logic       cfg_busy_hi,
  input logic       cfg_busy_lo
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (init_pull_low && !load_grant && !io_active));

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2 && !init_sync) |=> (state == 3'd2 && !load_grant && !init_pull_low));

  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (load_grant && crc_err) |=> (init_pull_low && !load_grant && !io_active));

  assert_error_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd5) |=> (state == 3'd5));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    io_active |=> (io_active && !init_pull_low));

  assert_flags_released_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(io_active) |-> (!cfg_busy_hi && cfg_busy_lo && !load_grant));

  assert_no_pull_when_active_R8: assert property (@(posedge clk) disable iff (rst)
    !(init_pull_low && io_active));
endmodule

bind cfg_startup_seq cfg_startup_seq_chk u_chk (
  .clk(clk), .rst(rst), .state(state), .init_sync(init_s2),
  .init_pull_low(init_pull_low), .load_grant(load_grant), .io_active(io_active),
  .crc_err(crc_err), .cfg_busy_hi(cfg_busy_hi), .cfg_busy_lo(cfg_busy_lo)
);

// File: tb/test_cfg_startup_seq.sv
`timescale 1ns/1ps
module test_cfg_startup_seq;
  localparam int SETTLE = 6;
  localparam int MW     = 10;

  logic clk = 0, rst = 1, master_mode = 0, init_in = 0;
  logic clear_done = 0, load_done = 0, crc_err = 0;
  logic init_pull_low, cfg_busy_hi, cfg_busy_lo, load_grant, io_active;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_startup_seq #(.SETTLE_CYCLES(SETTLE), .MASTER_WAIT(MW)) i_cfg_startup_seq (
    .clk(clk), .rst(rst), .master_mode(master_mode), .init_in(init_in),
    .clear_done(clear_done), .load_done(load_done), .crc_err(crc_err),
    .init_pull_low(init_pull_low), .cfg_busy_hi(cfg_busy_hi), .cfg_busy_lo(cfg_busy_lo),
    .load_grant(load_grant), .io_active(io_active)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; master_mode = 0; init_in = 0;
    clear_done = 0; load_done = 0; crc_err = 0;
    step(2);
    rst = 0;
  endtask

  task automatic to_wait();
    do_reset();
    step(SETTLE);
    clear_done = 1; step(1); clear_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(init_pull_low, 1, "R1 init_pull_low");
    chk(cfg_busy_hi, 1, "R1 cfg_busy_hi");
    chk(cfg_busy_lo, 0, "R1 cfg_busy_lo");
    chk(load_grant, 0, "R1 load_grant");
    chk(io_active, 0, "R1 io_active");
  endtask

  task automatic t_settle();
    do_reset();
    clear_done = 1; step(SETTLE); clear_done = 0;
    step(3);
    chk(init_pull_low, 1, "R2 clear_done ignored in settle");
    do_reset();
    clear_done = 1; step(SETTLE + 1); clear_done = 0;
    chk(init_pull_low, 0, "R2 settle length");
  endtask

  task automatic t_clear();
    do_reset();
    step(SETTLE + 5);
    chk(init_pull_low, 1, "R3 held until clear_done");
    clear_done = 1; step(1); clear_done = 0;
    chk(init_pull_low, 0, "R3 released after clear_done");
  endtask

  task automatic t_wait_slave();
    to_wait();
    step(12);
    chk(load_grant, 0, "R4 no grant while init low");
    chk(init_pull_low, 0, "R4 not pulling in wait");
    init_in = 1;
    step(2);
    chk(load_grant, 0, "R5 grant not before edge 3");
    step(1);
    chk(load_grant, 1, "R5 grant on edge 3");
  endtask

  task automatic t_master();
    to_wait();
    master_mode = 1; init_in = 1;
    step(2 + MW);
    chk(load_grant, 0, "R6 grant not before extra wait");
    step(1);
    chk(load_grant, 1, "R6 grant after extra wait");
  endtask

  task automatic t_error();
    to_wait();
    init_in = 1; step(3);
    crc_err = 1; load_done = 1; step(1); crc_err = 0; load_done = 0;
    chk(init_pull_low, 1, "R7 error pulls init");
    chk(load_grant, 0, "R7 error drops grant");
    chk(io_active, 0, "R7 error wins over load_done");
    load_done = 1; step(1); load_done = 0; step(4);
    chk(init_pull_low, 1, "R7 error sticky");
    chk(io_active, 0, "R7 error sticky io");
  endtask

  task automatic t_done();
    to_wait();
    init_in = 1; step(3);
    load_done = 1; step(1); load_done = 0;
    chk(io_active, 1, "R8 io_active");
    chk(cfg_busy_hi, 0, "R8 busy_hi released");
    chk(cfg_busy_lo, 1, "R8 busy_lo released");
    chk(init_pull_low, 0, "R8 init not pulled");
    chk(load_grant, 0, "R8 grant dropped");
    crc_err = 1; init_in = 0; step(1); crc_err = 0; step(4);
    chk(io_active, 1, "R9 io_active held");
    chk(init_pull_low, 0, "R9 no pull after crc_err");
  endtask

  task automatic t_ignored();
    to_wait();
    crc_err = 1; load_done = 1; step(1); crc_err = 0; load_done = 0;
    step(2);
    chk(init_pull_low, 0, "R10 crc_err ignored in wait");
    chk(io_active, 0, "R10 load_done ignored in wait");
    init_in = 1; step(3);
    chk(load_grant, 1, "R10 grant still reached");
  endtask

  initial begin
    step(1);
    t_reset();
    t_settle();
    t_clear();
    t_wait_slave();
    t_master();
    t_error();
    t_done();
    t_ignored();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule